// File: doc/BRIEF.md
# Single-Bus Accumulator Processor

This block is a small accumulator machine. Its working registers (program counter, instruction register, memory address register, memory buffer register, accumulator and the ALU's B-operand latch) all exchange data over one shared internal bus. Exactly one source may drive that bus in any cycle. The ALU's A operand is wired straight from the accumulator and never passes over the bus. A hardwired state machine steps each instruction through a fixed series of bus cycles.

The processor fetches 16-bit instruction words from a synchronous, word-addressed memory. The memory is driven through a registered address port, a write-data port and a write-enable. Read data comes back one clock after the address changes. The top four bits of an instruction select the operation and the low twelve bits give the operand address. The block is meant to run short programs held in an attached RAM: loads, stores, accumulator arithmetic and logic against memory, and jumps. It stops on a halt word.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `mem_we` and `halted` are 0 and `mem_addr` is 0. The first instruction is fetched from word 0.
- R2: A fetch places PC on `mem_addr`, waits one state for read data, then captures `mem_rdata` into IR. Operand reads use the same one-state wait. After reset, the first operand address of a load appears on `mem_addr` after the 6th rising edge.
- R3: At most one of the five bus sources (PC, IR address field, AC, MBR, ALU result) drives the internal bus in any cycle.
- R4: Opcode 0 (load) sets AC to the memory word at the instruction's 12-bit address.
- R5: Opcode 1 (store) writes AC to the instruction's address. `mem_we` is high for exactly one cycle per store, with `mem_wdata` equal to AC.
- R6: Opcode 2 sets AC to AC plus the memory operand, and opcode 3 sets AC to AC minus the memory operand. Both wrap modulo 2^16. The ALU codes used are 000 add and 001 subtract.
- R7: Opcodes 5, 6 and 7 set AC to AC AND, OR or XOR the memory operand. These use ALU codes 010, 011 and 100.
- R8: Opcode 4 (branch) loads PC with the address field. The next fetch comes from that address, with no increment.
- R9: Every instruction other than branch and halt leaves PC one higher, so the next fetch address is the previous one plus 1.
- R10: Opcode 15 (halt) raises `halted` and keeps it high. No further memory write occurs until `rst`, and `rst` clears `halted`.
- R11: Any opcode not listed above changes neither AC nor memory and only advances PC.
- R12: For the program load, store, halt started from reset, `mem_we` is seen high after rising edge 16 at address 0x082. `halted` rises after edge 22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory word address (registered MAR) |
| mem_rdata | input | 16 | Memory read data, valid one clock after the address |
| mem_wdata | output | 16 | Memory write data (registered MBR) |
| mem_we | output | 1 | Memory write enable, registered |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The assertions check the following on every cycle: a single bus driver, the one-state read wait ahead of instruction capture, a write strobe that never lasts beyond one cycle, and that `halted` cannot fall and never coincides with a write. The actual data results cannot be seen by a property at the ports. These are the sum, difference, logic values, loaded and stored words, the branch target, the no-op behaviour and the exact cycle on which each memory access happens. Only the bench's program runs show them, by inspecting the attached memory and the address port at counted edges.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OP_W = 4;
  localparam int NSRC = 5;
  localparam int SRC_PC  = 0;
  localparam int SRC_IR  = 1;
  localparam int SRC_AC  = 2;
  localparam int SRC_MBR = 3;
  localparam int SRC_ALU = 4;

  localparam logic [OP_W-1:0] OPC_LOAD  = 4'd0;
  localparam logic [OP_W-1:0] OPC_STORE = 4'd1;
  localparam logic [OP_W-1:0] OPC_ADD   = 4'd2;
  localparam logic [OP_W-1:0] OPC_SUB   = 4'd3;
  localparam logic [OP_W-1:0] OPC_JUMP  = 4'd4;
  localparam logic [OP_W-1:0] OPC_AND   = 4'd5;
  localparam logic [OP_W-1:0] OPC_OR    = 4'd6;
  localparam logic [OP_W-1:0] OPC_XOR   = 4'd7;
  localparam logic [OP_W-1:0] OPC_STOP  = 4'd15;

  typedef enum logic [2:0] {
    ALU_ADD   = 3'b000,
    ALU_SUB   = 3'b001,
    ALU_AND   = 3'b010,
    ALU_OR    = 3'b011,
    ALU_XOR   = 3'b100,
    ALU_NOTA  = 3'b101,
    ALU_PASSA = 3'b110,
    ALU_NOTB  = 3'b111
  } alu_op_e;

  typedef enum logic [3:0] {
    ST_INIT, ST_FADDR, ST_FWAIT, ST_FIR, ST_DEC,
    ST_OADDR, ST_OWAIT, ST_OMBR, ST_LDAC, ST_EXEC, ST_WRES,
    ST_STDATA, ST_STWR, ST_BRANCH, ST_INC, ST_HALT
  } cpu_state_e;

  typedef struct packed {
    logic [NSRC-1:0] src;
    logic            ld_pc;
    logic            pc_inc;
    logic            ld_ir;
    logic            ld_mar;
    logic            ld_mbr_bus;
    logic            ld_mbr_mem;
    logic            ld_b;
    logic            ld_ac;
    alu_op_e         op;
  } ctl_t;

  function automatic alu_op_e op_for(input logic [OP_W-1:0] opc);
    case (opc)
      OPC_SUB: op_for = ALU_SUB;
      OPC_AND: op_for = ALU_AND;
      OPC_OR:  op_for = ALU_OR;
      OPC_XOR: op_for = ALU_XOR;
      default: op_for = ALU_ADD;
    endcase
  endfunction
endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_op_e       op,
  output logic [DW-1:0] y
);
  always_comb begin
    case (op)
      ALU_ADD:   y = a + b;
      ALU_SUB:   y = a - b;
      ALU_AND:   y = a & b;
      ALU_OR:    y = a | b;
      ALU_XOR:   y = a ^ b;
      ALU_NOTA:  y = ~a;
      ALU_PASSA: y = a;
      default:   y = ~b;
    endcase
  end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output ctl_t            ctl,
  output logic            mem_we,
  output logic            halted
);
  cpu_state_e state, nxt;
  logic is_store, is_load, is_known_mem;

  assign is_store     = (opcode == OPC_STORE);
  assign is_load      = (opcode == OPC_LOAD);
  assign is_known_mem = is_load || is_store || (opcode == OPC_ADD) || (opcode == OPC_SUB) ||
                        (opcode == OPC_AND) || (opcode == OPC_OR) || (opcode == OPC_XOR);

  always_comb begin
    nxt    = state;
    ctl    = '0;
    ctl.op = op_for(opcode);
    case (state)
      ST_INIT:   nxt = ST_FADDR;
      ST_FADDR: begin
        ctl.src[SRC_PC] = 1'b1;
        ctl.ld_mar      = 1'b1;
        nxt             = ST_FWAIT;
      end
      ST_FWAIT:  nxt = ST_FIR;
      ST_FIR: begin
        ctl.ld_ir = 1'b1;
        nxt       = ST_DEC;
      end
      ST_DEC: begin
        if (is_known_mem)             nxt = ST_OADDR;
        else if (opcode == OPC_JUMP)  nxt = ST_BRANCH;
        else if (opcode == OPC_STOP)  nxt = ST_HALT;
        else                          nxt = ST_INC;
      end
      ST_OADDR: begin
        ctl.src[SRC_IR] = 1'b1;
        ctl.ld_mar      = 1'b1;
        nxt             = is_store ? ST_STDATA : ST_OWAIT;
      end
      ST_OWAIT:  nxt = ST_OMBR;
      ST_OMBR: begin
        ctl.ld_mbr_mem = 1'b1;
        nxt            = is_load ? ST_LDAC : ST_EXEC;
      end
      ST_LDAC: begin
        ctl.src[SRC_MBR] = 1'b1;
        ctl.ld_ac        = 1'b1;
        nxt              = ST_INC;
      end
      ST_EXEC: begin
        ctl.src[SRC_MBR] = 1'b1;
        ctl.ld_b         = 1'b1;
        nxt              = ST_WRES;
      end
      ST_WRES: begin
        ctl.src[SRC_ALU] = 1'b1;
        ctl.ld_ac        = 1'b1;
        nxt              = ST_INC;
      end
      ST_STDATA: begin
        ctl.src[SRC_AC] = 1'b1;
        ctl.ld_mbr_bus  = 1'b1;
        nxt             = ST_STWR;
      end
      ST_STWR:   nxt = ST_INC;
      ST_BRANCH: begin
        ctl.src[SRC_IR] = 1'b1;
        ctl.ld_pc       = 1'b1;
        nxt             = ST_FADDR;
      end
      ST_INC: begin
        ctl.pc_inc = 1'b1;
        nxt        = ST_FADDR;
      end
      default:   nxt = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_INIT;
      mem_we <= 1'b0;
      halted <= 1'b0;
    end else begin
      state  <= nxt;
      mem_we <= (nxt == ST_STWR);
      halted <= (nxt == ST_HALT);
    end
  end

  // R2: instruction capture only follows the read-wait state
  a_r2_fetch_wait: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FIR) |-> ($past(state) == ST_FWAIT));
  // R5: write strobe lasts one cycle
  a_r5_we_single: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
  // R10: halt is sticky until reset
  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  // R10: no write while halted
  a_r10_no_write: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  ctl_t            ctl,
  input  logic [DW-1:0]   mem_rdata,
  output logic [OP_W-1:0] opcode,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata
);
  logic [AW-1:0] pc, mar;
  logic [DW-1:0] ir, ac, mbr, breg, alu_y, bus;
  logic [DW-1:0] src_val [NSRC];

  assign src_val[SRC_PC]  = DW'(pc);
  assign src_val[SRC_IR]  = DW'(ir[AW-1:0]);
  assign src_val[SRC_AC]  = ac;
  assign src_val[SRC_MBR] = mbr;
  assign src_val[SRC_ALU] = alu_y;

  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++) bus = bus | (src_val[i] & {DW{ctl.src[i]}});
  end

  acc_alu #(.DW(DW)) alu_i (.a(ac), .b(breg), .op(ctl.op), .y(alu_y));

  always_ff @(posedge clk) begin
    if (rst) begin
      pc   <= '0;
      mar  <= '0;
      ir   <= '0;
      ac   <= '0;
      mbr  <= '0;
      breg <= '0;
    end else begin
      if (ctl.ld_pc)           pc   <= bus[AW-1:0];
      else if (ctl.pc_inc)     pc   <= pc + 1'b1;
      if (ctl.ld_mar)          mar  <= bus[AW-1:0];
      if (ctl.ld_ir)           ir   <= mem_rdata;
      if (ctl.ld_mbr_mem)      mbr  <= mem_rdata;
      else if (ctl.ld_mbr_bus) mbr  <= bus;
      if (ctl.ld_b)            breg <= bus;
      if (ctl.ld_ac)           ac   <= bus;
    end
  end

  assign opcode    = ir[DW-1 -: OP_W];
  assign mem_addr  = mar;
  assign mem_wdata = mbr;

  // R3: one bus driver per cycle
  a_r3_one_driver: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctl.src));
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          halted
);
  ctl_t            ctl;
  logic [OP_W-1:0] opcode;

  acc_ctrl ctrl_i (
    .clk(clk), .rst(rst), .opcode(opcode), .ctl(ctl),
    .mem_we(mem_we), .halted(halted)
  );

  acc_datapath #(.DW(DW), .AW(AW)) dp_i (
    .clk(clk), .rst(rst), .ctl(ctl), .mem_rdata(mem_rdata),
    .opcode(opcode), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );
endmodule

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic        halted;
  logic [15:0] mem [256];
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  acc_cpu dut_i (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .halted(halted)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  // op, operand A at 0x80, operand B at 0x81, expected word stored at 0x82
  localparam int NV = 9;
  localparam logic [51:0] VEC [NV] = '{
    {4'd2, 16'h1234, 16'h1111, 16'h2345},
    {4'd2, 16'hFFFF, 16'h0002, 16'h0001},
    {4'd3, 16'h5000, 16'h1234, 16'h3DCC},
    {4'd3, 16'h0001, 16'h0002, 16'hFFFF},
    {4'd5, 16'hF0F0, 16'h3C3C, 16'h3030},
    {4'd6, 16'hF000, 16'h000F, 16'hF00F},
    {4'd7, 16'hAAAA, 16'hFFFF, 16'h5555},
    {4'd0, 16'h1111, 16'hBEEF, 16'hBEEF},
    {4'd9, 16'h7777, 16'h0000, 16'h7777}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_to_halt(input int limit);
    for (int n = 0; n < limit && !halted; n++) @(negedge clk);
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0:       return "R4";
      4'd2, 4'd3: return "R6";
      4'd5, 4'd6, 4'd7: return "R7";
      default:    return "R11";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got %h expected %h", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    clear_mem();
    mem[0] = {4'd0, 12'h080};
    mem[1] = {4'd1, 12'h082};
    mem[2] = {4'd15, 12'h000};
    mem[8'h80] = 16'hC0DE;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!mem_we && !halted, "R1 outputs in reset", {30'd0, mem_we, halted}, 0);
    rst = 1'b0;
    // timing walk, R2 R9 R5 R12 R10
    for (int e = 1; e <= 22; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (e == 1)  check(mem_addr == 12'h000 && !mem_we, "R1 first fetch address", mem_addr, 0);
      if (e == 6)  check(mem_addr == 12'h080, "R2 operand address timing", mem_addr, 12'h080);
      if (e == 11) check(mem_addr == 12'h001, "R9 next fetch address", mem_addr, 12'h001);
      if (e == 15) check(!mem_we, "R12 no early write", mem_we, 0);
      if (e == 16) begin
        check(mem_we == 1'b1, "R12 write strobe edge 16", mem_we, 1);
        check(mem_addr == 12'h082, "R5 store address", mem_addr, 12'h082);
        check(mem_wdata == 16'hC0DE, "R5 store data", mem_wdata, 16'hC0DE);
      end
      if (e == 17) check(!mem_we, "R5 single cycle write", mem_we, 0);
      if (e == 21) check(!halted, "R12 halted not early", halted, 0);
      if (e == 22) check(halted, "R12 halted at edge 22", halted, 1);
    end
    check(mem[8'h82] == 16'hC0DE, "R4 R5 load then store", mem[8'h82], 16'hC0DE);

    // R10: halt holds, no writes
    begin
      int wr = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (mem_we) wr++;
        if (!halted) wr += 100;
      end
      check(wr == 0, "R10 halt holds without writes", wr, 0);
    end

    // vector table: R4 R6 R7 R11
    foreach (VEC[v]) begin
      clear_mem();
      mem[0] = {4'd0, 12'h080};
      mem[1] = {VEC[v][51:48], 12'h081};
      mem[2] = {4'd1, 12'h082};
      mem[3] = {4'd15, 12'h000};
      mem[8'h80] = VEC[v][47:32];
      mem[8'h81] = VEC[v][31:16];
      mem[8'h82] = 16'hDEAD;
      do_reset();
      check(!halted, "R10 reset clears halted", halted, 0);
      run_to_halt(200);
      @(negedge clk);
      check(mem[8'h82] == VEC[v][15:0], tag_of(VEC[v][51:48]), mem[8'h82], VEC[v][15:0]);
    end

    // R11: unknown opcode leaves memory alone and only advances
    clear_mem();
    mem[0] = {4'd12, 12'h085};
    mem[1] = {4'd15, 12'h000};
    mem[8'h85] = 16'h4242;
    do_reset();
    run_to_halt(200);
    check(mem[8'h85] == 16'h4242, "R11 memory untouched", mem[8'h85], 16'h4242);

    // R8: branch skips words 1..3
    clear_mem();
    mem[0] = {4'd4, 12'h010};
    mem[1] = {4'd0, 12'h081};
    mem[2] = {4'd1, 12'h083};
    mem[3] = {4'd15, 12'h000};
    mem[8'h10] = {4'd0, 12'h080};
    mem[8'h11] = {4'd1, 12'h082};
    mem[8'h12] = {4'd15, 12'h000};
    mem[8'h80] = 16'h0A0A;
    mem[8'h81] = 16'h0B0B;
    mem[8'h83] = 16'h5A5A;
    do_reset();
    for (int e = 1; e <= 7; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (e == 7) check(mem_addr == 12'h010, "R8 fetch from target", mem_addr, 12'h010);
    end
    run_to_halt(300);
    @(negedge clk);
    check(mem[8'h82] == 16'h0A0A, "R8 target code ran", mem[8'h82], 16'h0A0A);
    check(mem[8'h83] == 16'h5A5A, "R8 skipped code did not run", mem[8'h83], 16'h5A5A);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule